// File: doc/BRIEF.md
# Mode-Banked Shadow Register File

This block holds the 64-bit integer registers of a core: two combinational read ports and one clocked write port, each addressed by a 5-bit register number. Entry 31 is a constant zero. Registers 0 to 30 live in a main array.

A privileged-mode input gives firmware a private set of working registers. While that input is high, a fixed, non-contiguous group of register numbers is redirected to an 8-entry shadow bank. Reads and writes are redirected in the same way, so firmware can use those numbers freely without saving or disturbing the values that normal code left behind. All other numbers still reach the main array in either mode. A write and a read that land on the same location in the same cycle return the data being written, so one forwarding path is built into the block.

Top module: `shadow_regfile`

## Requirements
- R1: With `priv_i` low, register numbers 0 to 30 address 31 main entries. A value written at a clock edge is returned by any later read of that number until it is overwritten.
- R2: With `priv_i` high, register numbers 8 to 14 address shadow entries 0 to 6 in that order, and register number 25 addresses shadow entry 7. Every other number from 0 to 30 still addresses the main array, so a privileged write to register 5 is seen by a normal-mode read of register 5.
- R3: Register number 31 always reads as zero on both read ports in both modes. A write to it changes no entry.
- R4: A privileged write to a redirected number does not change what normal mode reads at that number. A normal-mode write to that number does not change what privileged mode reads there.
- R5: The two read ports are independent. They may address different registers or the same register in one cycle, and each returns its own value.
- R6: When `we_i` is high and the write resolves to the same stored location as a read port in that cycle, that port returns `w_data_i` in the same cycle. This never applies to register number 31.
- R7: While `rst_ni` is low, and after it is released, every main and shadow entry reads as zero until it is written.
- R8: A write uses the mapping selected by the value `priv_i` has in the cycle of the write. If `priv_i` changes in that cycle, the new mode's mapping applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Privileged mode, enables shadow redirection |
| ra_idx_i | input | 5 | Read port A register number |
| rb_idx_i | input | 5 | Read port B register number |
| we_i | input | 1 | Write enable |
| w_idx_i | input | 5 | Write register number |
| w_data_i | input | 64 | Write data |
| ra_data_o | output | 64 | Read port A data, combinational |
| rb_data_o | output | 64 | Read port B data, combinational |

## Verification
A fault in the remapping shows up as crosstalk between modes: a privileged write surfaces in a normal-mode read of the same number, or a non-redirected register reads differently across modes. This is visible on the first read after the write, one edge later. A fault in the storage or the zero entry shows up on the read data as soon as the affected number is addressed. A broken forwarding path shows up as stale data in the write cycle itself. Each of these is therefore caught one cycle after the faulty write at the latest, provided the bench reads that location in the opposite mode as well as the same mode.

// File: rtl/sbrf_pkg.sv
package sbrf_pkg;
  parameter int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    LOC_ZERO   = 2'd0,
    LOC_MAIN   = 2'd1,
    LOC_SHADOW = 2'd2
  } loc_kind_e;

  typedef struct packed {
    loc_kind_e         kind;
    logic [ADDR_W-1:0] slot;
  } loc_t;
endpackage

// File: rtl/sbrf_remap.sv
module sbrf_remap
  import sbrf_pkg::*;
#(
  parameter int unsigned SHADOW_BASE  = 8,
  parameter int unsigned SHADOW_RUN   = 7,
  parameter int unsigned SHADOW_EXTRA = 25
) (
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] idx_i,
  output loc_t              loc_o
);
  localparam logic [ADDR_W-1:0] ZERO_L  = '1;
  localparam logic [ADDR_W-1:0] BASE_L  = ADDR_W'(SHADOW_BASE);
  localparam logic [ADDR_W-1:0] LAST_L  = ADDR_W'(SHADOW_BASE + SHADOW_RUN - 1);
  localparam logic [ADDR_W-1:0] EXTRA_L = ADDR_W'(SHADOW_EXTRA);
  localparam logic [ADDR_W-1:0] RUN_L   = ADDR_W'(SHADOW_RUN);

  always_comb begin
    loc_o.kind = LOC_MAIN;
    loc_o.slot = idx_i;
    if (idx_i == ZERO_L) begin
      loc_o.kind = LOC_ZERO;
      loc_o.slot = '0;
    end else if (priv_i) begin
      if (idx_i >= BASE_L && idx_i <= LAST_L) begin
        loc_o.kind = LOC_SHADOW;
        loc_o.slot = idx_i - BASE_L;
      end else if (idx_i == EXTRA_L) begin
        loc_o.kind = LOC_SHADOW;
        loc_o.slot = RUN_L;
      end
    end
  end
endmodule

// File: rtl/sbrf_bank.sv
module sbrf_bank #(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  rsel_a_i,
  input  logic [SEL_W-1:0]  rsel_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam logic [SEL_W:0] DEPTH_L = (SEL_W+1)'(DEPTH);

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(e);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= '0;
      else if (we_i && wsel_i == MY_SEL) q <= wdata_i;
    end
    assign ent[e] = q;
  end

  assign rdata_a_o = ({1'b0, rsel_a_i} < DEPTH_L) ? ent[rsel_a_i] : '0;
  assign rdata_b_o = ({1'b0, rsel_b_i} < DEPTH_L) ? ent[rsel_b_i] : '0;
endmodule

// File: rtl/sbrf_rdport.sv
module sbrf_rdport
  import sbrf_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  loc_t              rloc_i,
  input  loc_t              wloc_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] main_i,
  input  logic [DATA_W-1:0] shadow_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  assign hit = we_i && (rloc_i.kind != LOC_ZERO) && (rloc_i == wloc_i);

  always_comb begin
    unique case (rloc_i.kind)
      LOC_MAIN:   rdata_o = hit ? wdata_i : main_i;
      LOC_SHADOW: rdata_o = hit ? wdata_i : shadow_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import sbrf_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned SHADOW_N     = 8,
  parameter int unsigned SHADOW_BASE  = 8,
  parameter int unsigned SHADOW_EXTRA = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic [4:0]        ra_idx_i,
  input  logic [4:0]        rb_idx_i,
  input  logic              we_i,
  input  logic [4:0]        w_idx_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o
);
  localparam int unsigned MAIN_N     = (1 << ADDR_W) - 1;
  localparam int unsigned SHADOW_RUN = SHADOW_N - 1;
  localparam int unsigned SH_W       = $clog2(SHADOW_N);
  localparam int unsigned NPORT      = 3;  // A, B, write

  logic [ADDR_W-1:0] idx [NPORT];
  loc_t              loc [NPORT];

  assign idx[0] = ra_idx_i;
  assign idx[1] = rb_idx_i;
  assign idx[2] = w_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    sbrf_remap #(
      .SHADOW_BASE (SHADOW_BASE),
      .SHADOW_RUN  (SHADOW_RUN),
      .SHADOW_EXTRA(SHADOW_EXTRA)
    ) u_remap (
      .priv_i(priv_i),
      .idx_i (idx[p]),
      .loc_o (loc[p])
    );
  end

  logic              main_we, shadow_we;
  logic [DATA_W-1:0] main_rd   [2];
  logic [DATA_W-1:0] shadow_rd [2];
  logic [DATA_W-1:0] port_rd   [2];

  assign main_we   = we_i && loc[2].kind == LOC_MAIN;
  assign shadow_we = we_i && loc[2].kind == LOC_SHADOW;

  sbrf_bank #(.DEPTH(MAIN_N), .DATA_W(DATA_W), .SEL_W(ADDR_W)) u_main (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (main_we),
    .wsel_i   (loc[2].slot),
    .wdata_i  (w_data_i),
    .rsel_a_i (loc[0].slot),
    .rsel_b_i (loc[1].slot),
    .rdata_a_o(main_rd[0]),
    .rdata_b_o(main_rd[1])
  );

  sbrf_bank #(.DEPTH(SHADOW_N), .DATA_W(DATA_W), .SEL_W(SH_W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (shadow_we),
    .wsel_i   (loc[2].slot[SH_W-1:0]),
    .wdata_i  (w_data_i),
    .rsel_a_i (loc[0].slot[SH_W-1:0]),
    .rsel_b_i (loc[1].slot[SH_W-1:0]),
    .rdata_a_o(shadow_rd[0]),
    .rdata_b_o(shadow_rd[1])
  );

  for (genvar r = 0; r < 2; r++) begin : g_rd
    sbrf_rdport #(.DATA_W(DATA_W)) u_rd (
      .rloc_i  (loc[r]),
      .wloc_i  (loc[2]),
      .we_i    (we_i),
      .wdata_i (w_data_i),
      .main_i  (main_rd[r]),
      .shadow_i(shadow_rd[r]),
      .rdata_o (port_rd[r])
    );
  end

  assign ra_data_o = port_rd[0];
  assign rb_data_o = port_rd[1];
endmodule

// File: rtl/sbrf_checker.sv
module sbrf_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              priv_i,
  input logic [4:0]        ra_idx_i,
  input logic [4:0]        rb_idx_i,
  input logic              we_i,
  input logic [4:0]        w_idx_i,
  input logic [DATA_W-1:0] w_data_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [DATA_W-1:0] rb_data_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  function automatic logic banked(input logic [4:0] i);
    return (i >= 5'd8 && i <= 5'd14) || i == 5'd25;
  endfunction

  logic wr_hits_a;
  assign wr_hits_a = we_i && w_idx_i == ra_idx_i;

  AST_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_idx_i == 5'd31 |-> ra_data_o == '0);  // R3
  AST_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_idx_i == 5'd31 |-> rb_data_o == '0);  // R3
  AST_FWD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hits_a && w_idx_i != 5'd31 |-> ra_data_o == w_data_i);  // R6
  AST_KEEP_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age != 2'd0 && $past(we_i && !priv_i && w_idx_i != 5'd31) && !priv_i
    && ra_idx_i == $past(w_idx_i) && !wr_hits_a
    |-> ra_data_o == $past(w_data_i));  // R1
  AST_KEEP_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age != 2'd0 && $past(we_i && priv_i && w_idx_i != 5'd31) && priv_i
    && ra_idx_i == $past(w_idx_i) && !wr_hits_a
    |-> ra_data_o == $past(w_data_i));  // R2
  AST_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age == 2'd2 && !priv_i && $past(!priv_i, 2) && $past(priv_i)
    && ra_idx_i == $past(ra_idx_i, 2)
    && $past(!we_i || banked(w_idx_i)) && !we_i
    |-> ra_data_o == $past(ra_data_o, 2));  // R4
endmodule

bind shadow_regfile sbrf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shadow_regfile_tb_top.sv
`timescale 1ns/1ps
module shadow_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        priv_i = 1'b0;
  logic [4:0]  ra_idx_i = '0, rb_idx_i = '0, w_idx_i = '0;
  logic        we_i = 1'b0;
  logic [63:0] w_data_i = '0;
  logic [63:0] ra_data_o, rb_data_o;

  always #2.5 clk_i = ~clk_i;

  shadow_regfile dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic        priv;
    logic        we;
    logic [4:0]  w;
    logic [63:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [63:0] ea;
    logic [63:0] eb;
    logic [3:0]  req;
  } vec_t;

  // req field holds the requirement number each row targets
  localparam vec_t VECS [17] = '{
    '{1'b0, 1'b1, 5'd10, 64'hA0,  5'd10, 5'd31, 64'hA0,  64'h0,   4'd6},  // R6 R3
    '{1'b0, 1'b1, 5'd25, 64'hA1,  5'd10, 5'd25, 64'hA0,  64'hA1,  4'd1},  // R1
    '{1'b1, 1'b1, 5'd10, 64'hB0,  5'd10, 5'd5,  64'hB0,  64'h0,   4'd6},  // R6
    '{1'b1, 1'b0, 5'd0,  64'h0,   5'd10, 5'd25, 64'hB0,  64'h0,   4'd2},  // R2
    '{1'b0, 1'b0, 5'd0,  64'h0,   5'd10, 5'd25, 64'hA0,  64'hA1,  4'd4},  // R4
    '{1'b1, 1'b1, 5'd5,  64'hC5,  5'd5,  5'd8,  64'hC5,  64'h0,   4'd2},  // R2
    '{1'b0, 1'b0, 5'd0,  64'h0,   5'd5,  5'd8,  64'hC5,  64'h0,   4'd2},  // R2
    '{1'b0, 1'b1, 5'd31, 64'hFF,  5'd31, 5'd31, 64'h0,   64'h0,   4'd3},  // R3
    '{1'b1, 1'b1, 5'd31, 64'hFF,  5'd31, 5'd14, 64'h0,   64'h0,   4'd3},  // R3
    '{1'b1, 1'b1, 5'd14, 64'hE6,  5'd14, 5'd8,  64'hE6,  64'h0,   4'd6},  // R6
    '{1'b1, 1'b1, 5'd8,  64'hE0,  5'd14, 5'd8,  64'hE6,  64'hE0,  4'd2},  // R2
    '{1'b1, 1'b0, 5'd0,  64'h0,   5'd25, 5'd13, 64'h0,   64'h0,   4'd2},  // R2
    '{1'b1, 1'b1, 5'd25, 64'hE7,  5'd25, 5'd15, 64'hE7,  64'h0,   4'd6},  // R6
    '{1'b0, 1'b0, 5'd0,  64'h0,   5'd14, 5'd15, 64'h0,   64'h0,   4'd4},  // R4
    '{1'b1, 1'b0, 5'd0,  64'h0,   5'd25, 5'd14, 64'hE7,  64'hE6,  4'd2},  // R2
    '{1'b0, 1'b1, 5'd30, 64'hF30, 5'd30, 5'd0,  64'hF30, 64'h0,   4'd1},  // R1
    '{1'b0, 1'b0, 5'd0,  64'h0,   5'd30, 5'd30, 64'hF30, 64'hF30, 4'd5}   // R5
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic we, input logic [4:0] w,
                      input logic [63:0] wd, input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk_i);
    priv_i = p; we_i = we; w_idx_i = w; w_data_i = wd; ra_idx_i = ra; rb_idx_i = rb;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R7: reset state, both modes
    ra_idx_i = 5'd10; rb_idx_i = 5'd25; priv_i = 1'b1; #1;
    check(ra_data_o, 64'h0, "R7");
    check(rb_data_o, 64'h0, "R7");
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b0, 5'd0, 64'h0, 5'd3, 5'd25);
    check(ra_data_o, 64'h0, "R7");
    check(rb_data_o, 64'h0, "R7");

    for (int i = 0; i < 17; i++) begin
      step(VECS[i].priv, VECS[i].we, VECS[i].w, VECS[i].wd, VECS[i].ra, VECS[i].rb);
      check(ra_data_o, VECS[i].ea, $sformatf("R%0d row %0d port A", VECS[i].req, i));
      check(rb_data_o, VECS[i].eb, $sformatf("R%0d row %0d port B", VECS[i].req, i));
    end

    // R8: mode rises in the write cycle, write lands in shadow entry 1
    step(1'b1, 1'b1, 5'd9, 64'h99, 5'd0, 5'd0);
    step(1'b0, 1'b0, 5'd0, 64'h0, 5'd9, 5'd9);
    check(ra_data_o, 64'h0, "R8");
    step(1'b1, 1'b0, 5'd0, 64'h0, 5'd9, 5'd0);
    check(ra_data_o, 64'h99, "R8");
    // R8: mode falls in the write cycle, write lands in main entry 11
    step(1'b0, 1'b1, 5'd11, 64'h77, 5'd0, 5'd0);
    step(1'b1, 1'b0, 5'd0, 64'h0, 5'd11, 5'd0);
    check(ra_data_o, 64'h0, "R8");
    step(1'b0, 1'b0, 5'd0, 64'h0, 5'd11, 5'd0);
    check(ra_data_o, 64'h77, "R8");

    // R7: reset after use clears both banks
    @(negedge clk_i); rst_ni = 1'b0; we_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b0, 5'd0, 64'h0, 5'd10, 5'd30);
    check(ra_data_o, 64'h0, "R7");
    check(rb_data_o, 64'h0, "R7");
    step(1'b1, 1'b0, 5'd0, 64'h0, 5'd10, 5'd25);
    check(ra_data_o, 64'h0, "R7");
    check(rb_data_o, 64'h0, "R7");

    finish_run();
  end
endmodule